// File: doc/BRIEF.md
# Register Bank Prefix Decoder

This decode-stage block watches the instruction word stream for a one-word bank-select prefix. When it finds one at an instruction boundary, it latches a bank number for each of three operands: first source, second source and destination. It also latches the total byte length of the bundle, which is the prefix plus the instruction that follows it. From the next clock edge on, it presents those bank numbers as extra register-index bits for the instruction that follows. It drops back to bank 0 once that instruction's end strobe has been seen.

Data registers have four banks, so a data operand uses the full two-bit bank field. Address registers have only a primary and a secondary bank. The decoder tells the block, per operand, whether that operand names an address register. For such an operand the bank is cut to its low bit, and an error flag is raised if the field asked for a bank above 1. The register file and the rest of instruction decode sit outside this block.

Top module: `bankpfx_top`

## Requirements
- R1: While reset is high and on the cycle after it, `pfx_active`, `bank_err`, all three bank outputs and `bundle_len` are 0.
- R2: A word counts as a prefix when `word_valid` is high, the word is the first word of an instruction (after reset, after an end strobe, or right after a prefix), and bits 15:8 equal 0x71. `pfx_active` is high from the following cycle. A prefix that arrives with `insn_end` high still loads.
- R3: On a data operand, the bank comes from fixed prefix bits: first source from bits 3:2, second source from bits 1:0, destination from bits 5:4.
- R4: Bits 7:6 of the prefix give `bundle_len` in bytes: 0 gives 4, 1 gives 6, 2 gives 8 and 3 gives 10.
- R5: The selections hold through the words of the following instruction. The cycle after a non-prefix cycle with `insn_end` high, `pfx_active` and all outputs are 0.
- R6: When `opnd_areg` bit k is set (bit 0 first source, bit 1 second source, bit 2 destination), that operand's bank output is the low bit of its field. `bank_err` is high when any such operand has field bit 1 set while a prefix is active.
- R7: A prefix that arrives while another is pending replaces all latched fields and the length.
- R8: A 0x71 word in the middle of an instruction, or any word with `word_valid` low, leaves the state unchanged.
- R9: With no prefix active, all bank outputs and `bank_err` are 0 whatever `opnd_areg` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_word | input | 16 | Instruction stream word |
| word_valid | input | 1 | `instr_word` carries a word this cycle |
| insn_end | input | 1 | Current instruction ends this cycle |
| opnd_areg | input | 3 | Per operand: operand names an address register |
| src_bank | output | 2 | Bank for first source operand |
| src2_bank | output | 2 | Bank for second source operand |
| dst_bank | output | 2 | Bank for destination operand |
| bundle_len | output | 4 | Bundle length in bytes, 0 when idle |
| pfx_active | output | 1 | A prefix is in effect |
| bank_err | output | 1 | Address operand asked for a bank above 1 |

## Verification
The assertions take for granted that `insn_end` marks a real instruction end. They also assume the prefix word never raises an end strobe of its own except when it coincides with a new prefix. On that basis they treat any end strobe without a prefix hit as the release point. The stimulus meets this by driving end strobes only on the last word of a non-prefix instruction, or in the one case of a prefix with the strobe deliberately high. `opnd_areg` is treated as meaningful only while a prefix is active. The stimulus also sets it while idle to show that it has no effect there.

// File: rtl/bankpfx_pkg.sv
package bankpfx_pkg;
  localparam int OPND_N = 3;   // first source, second source, destination

  // Low bit of each operand's bank field inside the prefix word.
  function automatic int field_lsb(input int op);
    case (op)
      0:       return 2;  // first source
      1:       return 0;  // second source
      default: return 4;  // destination
    endcase
  endfunction
endpackage

// File: rtl/bankpfx_detect.sv
module bankpfx_detect #(
  parameter int WORD_W = 16,
  parameter int TAG_W  = 8,
  parameter logic [TAG_W-1:0] TAG = 8'h71
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word,
  input  logic              word_valid,
  input  logic              insn_end,
  output logic              hit
);
  logic at_start_q;

  assign hit = word_valid && at_start_q && (word[WORD_W-1 -: TAG_W] == TAG);

  // Track instruction boundaries so extension words are never taken as prefixes.
  always_ff @(posedge clk) begin
    if (rst)                   at_start_q <= 1'b1;
    else if (hit || insn_end)  at_start_q <= 1'b1;
    else if (word_valid)       at_start_q <= 1'b0;
  end
endmodule

// File: rtl/bankpfx_state.sv
module bankpfx_state #(
  parameter int BANK_W   = 2,
  parameter int OPND_N   = 3,
  parameter int SIZE_W   = 2,
  parameter int LEN_W    = 4,
  parameter int LEN_BASE = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           hit,
  input  logic                           insn_end,
  input  logic [OPND_N-1:0][BANK_W-1:0]  field_d,
  input  logic [SIZE_W-1:0]              size_d,
  output logic                           active_q,
  output logic [OPND_N-1:0][BANK_W-1:0]  field_q,
  output logic [LEN_W-1:0]               len_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      field_q  <= '0;
      len_q    <= '0;
    end else if (hit) begin
      active_q <= 1'b1;
      field_q  <= field_d;
      len_q    <= LEN_W'(LEN_BASE) + LEN_W'({size_d, 1'b0});
    end else if (insn_end) begin
      active_q <= 1'b0;
      field_q  <= '0;
      len_q    <= '0;
    end
  end
endmodule

// File: rtl/bankpfx_bank_map.sv
module bankpfx_bank_map #(
  parameter int BANK_W = 2
) (
  input  logic [BANK_W-1:0] field,
  input  logic              areg,
  input  logic              active,
  output logic [BANK_W-1:0] bank,
  output logic              err
);
  always_comb begin
    if (!active)   bank = '0;
    else if (areg) bank = BANK_W'(field[0]);
    else           bank = field;
    err = active && areg && (|field[BANK_W-1:1]);
  end
endmodule

// File: rtl/bankpfx_top.sv
module bankpfx_top #(
  parameter int WORD_W = 16,
  parameter int TAG_W  = 8,
  parameter logic [TAG_W-1:0] PFX_TAG = 8'h71,
  parameter int BANK_W = 2,
  parameter int SIZE_W = 2,
  parameter int SIZE_LSB = 6,
  parameter int LEN_BASE = 4,
  localparam int OPND_N = bankpfx_pkg::OPND_N,
  localparam int LEN_W  = $clog2(LEN_BASE + 2 * (2**SIZE_W - 1) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] instr_word,
  input  logic              word_valid,
  input  logic              insn_end,
  input  logic [OPND_N-1:0] opnd_areg,
  output logic [BANK_W-1:0] src_bank,
  output logic [BANK_W-1:0] src2_bank,
  output logic [BANK_W-1:0] dst_bank,
  output logic [LEN_W-1:0]  bundle_len,
  output logic              pfx_active,
  output logic              bank_err
);
  logic                          pfx_hit;
  logic [SIZE_W-1:0]             size_d;
  logic [OPND_N-1:0][BANK_W-1:0] field_d, field_q;
  logic [OPND_N-1:0][BANK_W-1:0] bank_o;
  logic [OPND_N-1:0]             err_o;

  bankpfx_detect #(.WORD_W(WORD_W), .TAG_W(TAG_W), .TAG(PFX_TAG)) u_detect (
    .clk(clk), .rst(rst), .word(instr_word), .word_valid(word_valid),
    .insn_end(insn_end), .hit(pfx_hit)
  );

  assign size_d = instr_word[SIZE_LSB +: SIZE_W];

  generate
    for (genvar i = 0; i < OPND_N; i++) begin : g_opnd
      localparam int LSB = bankpfx_pkg::field_lsb(i);
      assign field_d[i] = instr_word[LSB +: BANK_W];
      bankpfx_bank_map #(.BANK_W(BANK_W)) u_map (
        .field(field_q[i]), .areg(opnd_areg[i]), .active(pfx_active),
        .bank(bank_o[i]), .err(err_o[i])
      );
    end
  endgenerate

  bankpfx_state #(
    .BANK_W(BANK_W), .OPND_N(OPND_N), .SIZE_W(SIZE_W),
    .LEN_W(LEN_W), .LEN_BASE(LEN_BASE)
  ) u_state (
    .clk(clk), .rst(rst), .hit(pfx_hit), .insn_end(insn_end),
    .field_d(field_d), .size_d(size_d),
    .active_q(pfx_active), .field_q(field_q), .len_q(bundle_len)
  );

  assign src_bank  = bank_o[0];
  assign src2_bank = bank_o[1];
  assign dst_bank  = bank_o[2];
  assign bank_err  = |err_o;
endmodule

// File: rtl/bankpfx_checker.sv
module bankpfx_checker #(
  parameter int BANK_W = 2,
  parameter int SIZE_W = 2,
  parameter int LEN_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              hit,
  input logic              insn_end,
  input logic [SIZE_W-1:0] size_code,
  input logic              pfx_active,
  input logic [LEN_W-1:0]  bundle_len,
  input logic              bank_err,
  input logic [BANK_W-1:0] src_bank,
  input logic [BANK_W-1:0] src2_bank,
  input logic [BANK_W-1:0] dst_bank
);
  assert_hit_sets_R2: assert property (@(posedge clk) disable iff (rst)
    hit |=> pfx_active);

  assert_len_code_R4: assert property (@(posedge clk) disable iff (rst)
    hit |=> (bundle_len == LEN_W'(4) + LEN_W'({$past(size_code), 1'b0})));

  assert_end_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (insn_end && !hit) |=> !pfx_active);

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (pfx_active && !insn_end && !hit) |=> (pfx_active && $stable(bundle_len)));

  assert_err_active_R6: assert property (@(posedge clk) disable iff (rst)
    bank_err |-> pfx_active);

  assert_replace_R7: assert property (@(posedge clk) disable iff (rst)
    (pfx_active && hit) |=> pfx_active);

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !pfx_active |-> (src_bank == '0 && src2_bank == '0 && dst_bank == '0
                     && !bank_err && bundle_len == '0));
endmodule

bind bankpfx_top bankpfx_checker #(.BANK_W(BANK_W), .SIZE_W(SIZE_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .hit(pfx_hit), .insn_end(insn_end), .size_code(size_d),
  .pfx_active(pfx_active), .bundle_len(bundle_len), .bank_err(bank_err),
  .src_bank(src_bank), .src2_bank(src2_bank), .dst_bank(dst_bank)
);

// File: tb/tb_bankpfx_top.sv
module tb_bankpfx_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr_word = '0;
  logic        word_valid = 1'b0;
  logic        insn_end = 1'b0;
  logic [2:0]  opnd_areg = '0;
  logic [1:0]  src_bank, src2_bank, dst_bank;
  logic [3:0]  bundle_len;
  logic        pfx_active, bank_err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bankpfx_top dut (
    .clk(clk), .rst(rst), .instr_word(instr_word), .word_valid(word_valid),
    .insn_end(insn_end), .opnd_areg(opnd_areg), .src_bank(src_bank),
    .src2_bank(src2_bank), .dst_bank(dst_bank), .bundle_len(bundle_len),
    .pfx_active(pfx_active), .bank_err(bank_err)
  );

  // Entry: req(4) word(16) valid end areg(3) | expected {act,src,src2,dst,len(4),err}
  localparam int NVEC = 15;
  localparam logic [36:0] VEC [NVEC] = '{
    {4'd9, 16'h0000, 1'b0, 1'b0, 3'b000, 1'b0, 2'd0, 2'd0, 2'd0, 4'd0,  1'b0}, // R9 idle
    {4'd3, 16'h71E4, 1'b1, 1'b0, 3'b000, 1'b1, 2'd1, 2'd0, 2'd2, 4'd10, 1'b0}, // R2 R3 R4
    {4'd5, 16'h3010, 1'b1, 1'b0, 3'b000, 1'b1, 2'd1, 2'd0, 2'd2, 4'd10, 1'b0}, // R5 hold
    {4'd8, 16'h71AA, 1'b1, 1'b0, 3'b100, 1'b1, 2'd1, 2'd0, 2'd0, 4'd10, 1'b1}, // R8 mid word, R6 dst
    {4'd5, 16'h0005, 1'b1, 1'b1, 3'b000, 1'b0, 2'd0, 2'd0, 2'd0, 4'd0,  1'b0}, // R5 release
    {4'd4, 16'h711B, 1'b1, 1'b0, 3'b000, 1'b1, 2'd2, 2'd3, 2'd1, 4'd4,  1'b0}, // R3 R4
    {4'd7, 16'h7166, 1'b1, 1'b0, 3'b011, 1'b1, 2'd1, 2'd0, 2'd2, 4'd6,  1'b1}, // R7 replace, R6
    {4'd8, 16'h7155, 1'b0, 1'b0, 3'b000, 1'b1, 2'd1, 2'd2, 2'd2, 4'd6,  1'b0}, // R8 invalid word
    {4'd9, 16'h4E75, 1'b1, 1'b1, 3'b111, 1'b0, 2'd0, 2'd0, 2'd0, 4'd0,  1'b0}, // R9 areg while idle
    {4'd2, 16'h7150, 1'b1, 1'b1, 3'b000, 1'b1, 2'd0, 2'd0, 2'd1, 4'd6,  1'b0}, // R2 prefix with end
    {4'd5, 16'h1234, 1'b1, 1'b0, 3'b000, 1'b1, 2'd0, 2'd0, 2'd1, 4'd6,  1'b0}, // R5 hold
    {4'd5, 16'h0000, 1'b0, 1'b1, 3'b000, 1'b0, 2'd0, 2'd0, 2'd0, 4'd0,  1'b0}, // R5 end alone
    {4'd2, 16'h70FF, 1'b1, 1'b1, 3'b000, 1'b0, 2'd0, 2'd0, 2'd0, 4'd0,  1'b0}, // R2 wrong tag
    {4'd4, 16'h71C0, 1'b1, 1'b0, 3'b000, 1'b1, 2'd0, 2'd0, 2'd0, 4'd10, 1'b0}, // R4
    {4'd5, 16'h0008, 1'b1, 1'b1, 3'b000, 1'b0, 2'd0, 2'd0, 2'd0, 4'd0,  1'b0}  // R5
  };

  function automatic logic [11:0] outs();
    return {pfx_active, src_bank, src2_bank, dst_bank, bundle_len, bank_err};
  endfunction

  task automatic check(input string tag, input logic [11:0] exp);
    n_run++;
    if (outs() !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, outs(), exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 check("R1 reset", 12'h000);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      instr_word = VEC[i][32:17];
      word_valid = VEC[i][16];
      insn_end   = VEC[i][15];
      opnd_areg  = VEC[i][14:12];
      @(posedge clk);
      #2 check($sformatf("R%0d vec %0d", VEC[i][36:33], i), VEC[i][11:0]);
    end

    // R1: reset during a pending prefix clears everything
    @(negedge clk);
    instr_word = 16'h71FF; word_valid = 1'b1; insn_end = 1'b0; opnd_areg = 3'b000;
    @(posedge clk);
    #2 check("R4 pre-reset load", {1'b1, 2'd3, 2'd3, 2'd3, 4'd10, 1'b0});
    @(negedge clk);
    word_valid = 1'b0; rst = 1'b1;
    @(posedge clk);
    #2 check("R1 reset mid prefix", 12'h000);
    @(negedge clk) rst = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule